// File: doc/BRIEF.md
# Virtual-Link Rate Policer

This block decides, frame by frame, whether traffic on a critical virtual link conforms to its contract. Each request carries a link number, a frame length and an arrival timestamp taken from an external free-running 32-bit time base. The block answers with a pass or drop verdict one cycle later. Each link has its own configuration: a largest allowed length, a minimum spacing between accepted frames, a jitter allowance that relaxes that spacing, and an index into a small pool of shared policing entries.

The shared entries hold the rate state, which is the time of the last accepted frame and whether any frame has been accepted yet. Any number of links may point at one entry, and they then draw on a single budget: a frame accepted on one of them delays the next acceptable frame on all of them. A frame fails if it is too long, or if it follows the entry's last accepted frame by less than the spacing minus the jitter. The subtraction saturates at zero. When a link's spacing and jitter are both zero, the spacing check is switched off. Configuration is written one link at a time through a write strobe with its data.

Top module: `vl_rate_policer`

## Requirements
- R1: After reset `vrdValid` is low and every link reads as maximum length 0, spacing 0, jitter 0 and shared index 0. A zero-length frame on such a link passes, and a frame of length 1 is dropped.
- R2: Each cycle with `reqValid` high produces exactly one cycle of `vrdValid` on the following cycle, and `vrdValid` is never high otherwise. `vrdPass` is low whenever `vrdValid` is low.
- R3: A frame whose `reqLen` is greater than its link's maximum length is dropped. A frame whose length equals the maximum may pass.
- R4: With the spacing check on, a frame passes the check when (`reqTime` − last accepted time of its entry) is at least max(spacing − jitter, 0). Otherwise it is dropped.
- R5: A link whose spacing and jitter are both 0 applies only the length check.
- R6: The first frame on a shared entry after reset passes the spacing check whatever the link's spacing.
- R7: An entry's last accepted time changes only on a pass verdict. A frame dropped for length or for spacing leaves it unchanged.
- R8: Links with the same shared index share one last-accepted time. Links with different indices do not affect each other.
- R9: A configuration write takes effect for requests from the next cycle on. A request in the same cycle as a write to its link is judged with the old settings.
- R10: The time difference is taken modulo 2^32, so a timestamp that has wrapped past zero is measured correctly.
- R11: Back-to-back requests on links that share an entry are judged in order. The second request sees the first one's update when the first passes, and sees no update when the first is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Write strobe for one link's configuration |
| cfgLinkId | input | 4 | Link being configured |
| cfgMaxLen | input | 12 | Largest allowed frame length |
| cfgBag | input | 16 | Minimum spacing between accepted frames, in time-base ticks |
| cfgJitter | input | 16 | Tolerance subtracted from the spacing, in ticks |
| cfgShareIdx | input | 3 | Shared policing entry used by the link |
| reqValid | input | 1 | A frame is presented for policing |
| reqLinkId | input | 4 | Link of the frame |
| reqLen | input | 12 | Frame length |
| reqTime | input | 32 | Arrival timestamp |
| vrdValid | output | 1 | Verdict is valid this cycle |
| vrdPass | output | 1 | 1 = frame accepted, 0 = frame dropped |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a configuration write and a policing request on the link being rewritten. The bench drives both on one clock edge. It expects the verdict that the old maximum length gives, and it then checks that the next frame is judged by the new value. The second pair is an update to the shared state and a lookup of that state. The bench sends two requests on consecutive cycles on links that share an entry, once with the first frame accepted and once with it dropped. It expects the second verdict to reflect the first one's update only when the first frame passed.

// File: rtl/vlp_pkg.sv
package vlp_pkg;
  // Strobes from control to datapath for one cycle.
  typedef struct packed {
    logic cfgWrite;  // store one link configuration
    logic evaluate;  // judge the presented frame
  } vlpStrobes_t;
endpackage

// File: rtl/vlp_gap_check.sv
module vlp_gap_check #(
  parameter int TS_W  = 32,
  parameter int GAP_W = 16
) (
  input  logic             seen,
  input  logic [GAP_W-1:0] bag,
  input  logic [GAP_W-1:0] jitter,
  input  logic [TS_W-1:0]  nowTime,
  input  logic [TS_W-1:0]  lastTime,
  output logic             gapOk
);
  logic [GAP_W-1:0] needGap;
  logic [TS_W-1:0]  elapsed;
  logic             checkOff;

  // Saturating allowance: the spacing minus the tolerance, floored at zero.
  assign needGap  = (bag > jitter) ? (bag - jitter) : '0;
  // Wraps naturally modulo 2^TS_W.
  assign elapsed  = nowTime - lastTime;
  assign checkOff = (bag == '0) && (jitter == '0);
  assign gapOk    = !seen || checkOff || (elapsed >= TS_W'(needGap));
endmodule

// File: rtl/vlp_ctrl.sv
module vlp_ctrl
  import vlp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic        reqValid,
  output vlpStrobes_t strobes,
  output logic        vrdValid
);
  always_comb begin
    strobes          = '0;
    strobes.cfgWrite = cfgWrEn;
    strobes.evaluate = reqValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vrdValid <= 1'b0;
    else       vrdValid <= reqValid;
  end
endmodule

// File: rtl/vlp_datapath.sv
module vlp_datapath
  import vlp_pkg::*;
#(
  parameter int NUM_LINKS  = 16,
  parameter int NUM_SHARED = 8,
  parameter int LEN_W      = 12,
  parameter int GAP_W      = 16,
  parameter int TS_W       = 32,
  localparam int LINK_W    = $clog2(NUM_LINKS),
  localparam int SHR_W     = $clog2(NUM_SHARED)
) (
  input  logic              clk,
  input  logic              rstN,
  input  vlpStrobes_t       strobes,
  input  logic [LINK_W-1:0] cfgLinkId,
  input  logic [LEN_W-1:0]  cfgMaxLen,
  input  logic [GAP_W-1:0]  cfgBag,
  input  logic [GAP_W-1:0]  cfgJitter,
  input  logic [SHR_W-1:0]  cfgShareIdx,
  input  logic [LINK_W-1:0] reqLinkId,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [TS_W-1:0]   reqTime,
  output logic              vrdPass
);
  // Per-link configuration table.
  logic [LEN_W-1:0] maxLenQ [NUM_LINKS];
  logic [GAP_W-1:0] bagQ    [NUM_LINKS];
  logic [GAP_W-1:0] jitterQ [NUM_LINKS];
  logic [SHR_W-1:0] shrQ    [NUM_LINKS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINKS; i++) begin
        maxLenQ[i] <= '0;
        bagQ[i]    <= '0;
        jitterQ[i] <= '0;
        shrQ[i]    <= '0;
      end
    end else if (strobes.cfgWrite) begin
      maxLenQ[cfgLinkId] <= cfgMaxLen;
      bagQ[cfgLinkId]    <= cfgBag;
      jitterQ[cfgLinkId] <= cfgJitter;
      shrQ[cfgLinkId]    <= cfgShareIdx;
    end
  end

  // Settings of the link of the presented frame.
  logic [LEN_W-1:0] selMax;
  logic [GAP_W-1:0] selBag;
  logic [GAP_W-1:0] selJitter;
  logic [SHR_W-1:0] selShr;

  assign selMax    = maxLenQ[reqLinkId];
  assign selBag    = bagQ[reqLinkId];
  assign selJitter = jitterQ[reqLinkId];
  assign selShr    = shrQ[reqLinkId];

  // Shared policing state, one register set per entry.
  logic [TS_W-1:0]       lastTime [NUM_SHARED];
  logic [NUM_SHARED-1:0] seenVec;
  logic [NUM_SHARED-1:0] entryHit;
  logic                  framePass;

  for (genvar e = 0; e < NUM_SHARED; e++) begin : g_entry
    logic [TS_W-1:0] lastQ;
    logic            seenQ;

    assign entryHit[e] = (selShr == SHR_W'(e));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lastQ <= '0;
        seenQ <= 1'b0;
      end else if (strobes.evaluate && framePass && entryHit[e]) begin
        lastQ <= reqTime;
        seenQ <= 1'b1;
      end
    end

    assign lastTime[e] = lastQ;
    assign seenVec[e]  = seenQ;
  end

  logic gapOk;
  logic lenOk;

  vlp_gap_check #(.TS_W(TS_W), .GAP_W(GAP_W)) uGap (
    .seen     (seenVec[selShr]),
    .bag      (selBag),
    .jitter   (selJitter),
    .nowTime  (reqTime),
    .lastTime (lastTime[selShr]),
    .gapOk    (gapOk)
  );

  assign lenOk     = (reqLen <= selMax);
  assign framePass = lenOk && gapOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vrdPass <= 1'b0;
    else       vrdPass <= strobes.evaluate && framePass;
  end
endmodule

// File: rtl/vl_rate_policer.sv
module vl_rate_policer
  import vlp_pkg::*;
#(
  parameter int NUM_LINKS  = 16,
  parameter int NUM_SHARED = 8,
  parameter int LEN_W      = 12,
  parameter int GAP_W      = 16,
  parameter int TS_W       = 32,
  localparam int LINK_W    = $clog2(NUM_LINKS),
  localparam int SHR_W     = $clog2(NUM_SHARED)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [LINK_W-1:0] cfgLinkId,
  input  logic [LEN_W-1:0]  cfgMaxLen,
  input  logic [GAP_W-1:0]  cfgBag,
  input  logic [GAP_W-1:0]  cfgJitter,
  input  logic [SHR_W-1:0]  cfgShareIdx,
  input  logic              reqValid,
  input  logic [LINK_W-1:0] reqLinkId,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [TS_W-1:0]   reqTime,
  output logic              vrdValid,
  output logic              vrdPass
);
  vlpStrobes_t strobes;

  vlp_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .reqValid (reqValid),
    .strobes  (strobes),
    .vrdValid (vrdValid)
  );

  vlp_datapath #(
    .NUM_LINKS  (NUM_LINKS),
    .NUM_SHARED (NUM_SHARED),
    .LEN_W      (LEN_W),
    .GAP_W      (GAP_W),
    .TS_W       (TS_W)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .cfgLinkId   (cfgLinkId),
    .cfgMaxLen   (cfgMaxLen),
    .cfgBag      (cfgBag),
    .cfgJitter   (cfgJitter),
    .cfgShareIdx (cfgShareIdx),
    .reqLinkId   (reqLinkId),
    .reqLen      (reqLen),
    .reqTime     (reqTime),
    .vrdPass     (vrdPass)
  );
endmodule

// File: rtl/vlp_checker.sv
module vlp_checker #(
  parameter int NUM_LINKS = 16,
  parameter int LEN_W     = 12,
  parameter int GAP_W     = 16,
  localparam int LINK_W   = $clog2(NUM_LINKS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [LINK_W-1:0] cfgLinkId,
  input logic [LEN_W-1:0]  cfgMaxLen,
  input logic [GAP_W-1:0]  cfgBag,
  input logic [GAP_W-1:0]  cfgJitter,
  input logic              reqValid,
  input logic [LINK_W-1:0] reqLinkId,
  input logic [LEN_W-1:0]  reqLen,
  input logic              vrdValid,
  input logic              vrdPass
);
  // Shadow of the written configuration, built from the write port.
  logic [LEN_W-1:0] shMax [NUM_LINKS];
  logic [GAP_W-1:0] shBag [NUM_LINKS];
  logic [GAP_W-1:0] shJit [NUM_LINKS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LINKS; i++) begin
        shMax[i] <= '0;
        shBag[i] <= '0;
        shJit[i] <= '0;
      end
    end else if (cfgWrEn) begin
      shMax[cfgLinkId] <= cfgMaxLen;
      shBag[cfgLinkId] <= cfgBag;
      shJit[cfgLinkId] <= cfgJitter;
    end
  end

  // R1: no verdict while reset is held.
  always @(posedge clk) begin
    if (!rstN) a_r1_idle_in_reset: assert (!vrdValid);
  end

  a_r2_verdict_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> vrdValid);

  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !vrdValid);

  a_r2_pass_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    !vrdValid |-> !vrdPass);

  a_r3_overlong_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqLen > shMax[reqLinkId])) |=> !vrdPass);

  a_r5_gap_off_passes: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (shBag[reqLinkId] == '0) && (shJit[reqLinkId] == '0)
     && (reqLen <= shMax[reqLinkId])) |=> vrdPass);
endmodule

bind vl_rate_policer vlp_checker #(
  .NUM_LINKS (NUM_LINKS),
  .LEN_W     (LEN_W),
  .GAP_W     (GAP_W)
) uChk (.*);

// File: tb/tb_vl_rate_policer.sv
`timescale 1ns/1ps
module tb_vl_rate_policer;
  localparam int NL = 16;
  localparam int NS = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [3:0]  cfgLinkId = '0;
  logic [11:0] cfgMaxLen = '0;
  logic [15:0] cfgBag = '0;
  logic [15:0] cfgJitter = '0;
  logic [2:0]  cfgShareIdx = '0;
  logic        reqValid = 1'b0;
  logic [3:0]  reqLinkId = '0;
  logic [11:0] reqLen = '0;
  logic [31:0] reqTime = '0;
  logic        vrdValid;
  logic        vrdPass;

  int testCount = 0;
  int failCount = 0;

  always #2 clk = ~clk;  // 250 MHz

  vl_rate_policer dut (.*);

  // Reference state computed from the requirements.
  int unsigned refMax [NL];
  int unsigned refBag [NL];
  int unsigned refJit [NL];
  int unsigned refShr [NL];
  logic [31:0] refLast [NS];
  bit          refSeen [NS];

  function automatic bit predict(int link, int len, logic [31:0] t);
    int unsigned need;
    logic [31:0] diff;
    bit ok;
    int s = int'(refShr[link]);
    need = (refBag[link] > refJit[link]) ? refBag[link] - refJit[link] : 0;
    diff = t - refLast[s];
    ok = (len <= int'(refMax[link])) &&
         (!refSeen[s] || (refBag[link] == 0 && refJit[link] == 0) || diff >= need);
    if (ok) begin
      refLast[s] = t;
      refSeen[s] = 1'b1;
    end
    return ok;
  endfunction

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: {valid,pass} got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic setRef(int link, int mx, int bag, int jit, int shr);
    refMax[link] = mx; refBag[link] = bag; refJit[link] = jit; refShr[link] = shr;
  endtask

  task automatic driveCfg(int link, int mx, int bag, int jit, int shr);
    cfgWrEn = 1'b1; cfgLinkId = 4'(link); cfgMaxLen = 12'(mx);
    cfgBag = 16'(bag); cfgJitter = 16'(jit); cfgShareIdx = 3'(shr);
  endtask

  task automatic cfg(int link, int mx, int bag, int jit, int shr);
    @(negedge clk);
    driveCfg(link, mx, bag, jit, shr);
    @(negedge clk);
    cfgWrEn = 1'b0;
    setRef(link, mx, bag, jit, shr);
  endtask

  task automatic driveReq(int link, int len, logic [31:0] t);
    reqValid = 1'b1; reqLinkId = 4'(link); reqLen = 12'(len); reqTime = t;
  endtask

  task automatic frame(string tag, int link, int len, logic [31:0] t);
    bit e;
    e = predict(link, len, t);
    @(negedge clk);
    driveReq(link, len, t);
    @(negedge clk);
    check(tag, {vrdValid, vrdPass}, {1'b1, e});
    reqValid = 1'b0;
  endtask

  // R11: two requests on consecutive cycles.
  task automatic pair(int la, int lena, logic [31:0] ta,
                      int lb, int lenb, logic [31:0] tb);
    bit ea, eb;
    ea = predict(la, lena, ta);
    eb = predict(lb, lenb, tb);
    @(negedge clk);
    driveReq(la, lena, ta);
    @(negedge clk);
    check("R11 first", {vrdValid, vrdPass}, {1'b1, ea});
    driveReq(lb, lenb, tb);
    @(negedge clk);
    check("R11 second", {vrdValid, vrdPass}, {1'b1, eb});
    reqValid = 1'b0;
  endtask

  // R9: write and request on the same link in one cycle.
  task automatic sameCycle(int link, int len, logic [31:0] t, int newMax);
    bit e;
    e = predict(link, len, t);
    @(negedge clk);
    driveCfg(link, newMax, 0, 0, int'(refShr[link]));
    driveReq(link, len, t);
    @(negedge clk);
    check("R9 old config", {vrdValid, vrdPass}, {1'b1, e});
    cfgWrEn = 1'b0;
    reqValid = 1'b0;
    setRef(link, newMax, 0, 0, int'(refShr[link]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [31:0] t;
    int bags [3] = '{0, 4, 9};
    int jits [4] = '{0, 2, 9, 12};
    for (int i = 0; i < NL; i++) setRef(i, 0, 0, 0, 0);
    for (int s = 0; s < NS; s++) begin refLast[s] = '0; refSeen[s] = 1'b0; end

    repeat (3) @(negedge clk);
    check("R1 valid in reset", {vrdValid, vrdPass}, 2'b00);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 valid after reset", {vrdValid, vrdPass}, 2'b00);

    // R1: reset configuration of link 0 (max 0, spacing off).
    frame("R1 zero length", 0, 0, 32'd100);
    frame("R1 length one", 0, 1, 32'd101);

    // R2: idle cycles give no verdict.
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R2 idle", {vrdValid, vrdPass}, 2'b00);
    end

    // R6: first frame on entry 6 passes despite a large spacing.
    cfg(7, 1500, 1000, 0, 6);
    frame("R6 first frame", 7, 64, 32'd5);
    frame("R4 too soon", 7, 64, 32'd10);

    // R3: length sweep around the maximum.
    cfg(1, 100, 0, 0, 1);
    for (int len = 90; len <= 110; len++) frame("R3 length", 1, len, 32'd200);

    // R4 / R5: spacing and jitter sweep.
    t = 32'd1000;
    foreach (bags[b]) foreach (jits[j]) begin
      cfg(1, 100, bags[b], jits[j], 1);
      for (int d = 0; d <= 12; d++) begin
        t = t + 32'(d);
        if (bags[b] == 0 && jits[j] == 0) frame("R5 spacing off", 1, 64, t);
        else frame("R4 spacing", 1, 64, t);
      end
      t = t + 32'd50;
    end

    // R7: drops must not move the last accepted time.
    cfg(8, 50, 10, 0, 2);
    frame("R7 base", 8, 40, 32'd5000);
    frame("R7 long drop", 8, 60, 32'd5012);
    frame("R7 after long drop", 8, 40, 32'd5015);
    frame("R7 base2", 8, 40, 32'd5030);
    frame("R7 gap drop", 8, 40, 32'd5035);
    frame("R7 after gap drop", 8, 40, 32'd5041);

    // R8: shared and separate entries.
    cfg(2, 100, 10, 0, 4);
    cfg(3, 100, 10, 0, 4);
    cfg(5, 100, 10, 0, 5);
    frame("R8 link2", 2, 64, 32'd6000);
    frame("R8 link3 shares", 3, 64, 32'd6005);
    frame("R8 link5 separate", 5, 64, 32'd6005);
    frame("R8 link3 later", 3, 64, 32'd6011);
    frame("R8 link2 after link3", 2, 64, 32'd6015);

    // R10: wrap of the time base.
    cfg(9, 100, 20, 0, 3);
    frame("R10 before wrap", 9, 64, 32'hFFFF_FFF0);
    frame("R10 across wrap", 9, 64, 32'h0000_0005);
    frame("R10 short after", 9, 64, 32'h0000_0014);
    frame("R10 exact need", 9, 64, 32'h0000_0019);

    // R11: back-to-back on shared entry 4.
    pair(2, 64, 32'd7000, 3, 64, 32'd7003);
    pair(2, 200, 32'd7020, 3, 64, 32'd7022);
    pair(3, 64, 32'd7040, 5, 64, 32'd7041);

    // R9: same-cycle write, then new config applies.
    cfg(1, 100, 0, 0, 1);
    sameCycle(1, 60, 32'd8000, 40);
    frame("R9 new config", 1, 60, 32'd8001);
    sameCycle(1, 60, 32'd8002, 80);
    frame("R9 raised max", 1, 60, 32'd8003);

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule